// File: doc/BRIEF.md
# Polled Priority Interrupt Controller

An eight-input priority interrupt controller for a host that never runs vector acknowledge cycles. The host reaches the block through a byte-wide port with two addresses. Address 0 takes command bytes and returns status bytes. Address 1 takes the mask and the init words. The block latches requests and applies a mask. It keeps an in-service register and ranks the levels in a rotating order whose lowest level can be programmed. It drives a single interrupt line.

The host starts in the interrupt handler. It writes a poll command and then reads address 0. The byte it reads holds a pending flag and the identity of the best request. That read also moves the request into service. When the host has serviced the device, it clears that level with a specific end-of-interrupt command. A request that disappears before the poll is reported as level 7 with nothing in service. The host confirms this by selecting the in-service register and reading it. Special mask mode lets masked in-service levels stop blocking the others.

Top module: `pic_poll_ctrl`

## Requirements
- R1: After reset the mask reads back 0xFF. The request and in-service registers are zero. The lowest level is 7, so IRQ0 ranks highest. An even read returns the request register (0x00), and int_o is low.
- R2: An even write with bit 4 set starts initialization. It clears the mask, the in-service register and the request latches. It clears special mask mode and any armed poll, selects the request register for reads, and sets the lowest level to 7. In that byte, bit 3 = 1 selects level mode, bit 1 = 1 skips the third init word, and bit 0 = 1 expects a fourth. The odd writes that follow are consumed as init words and do not change the mask.
- R3: Outside initialization, an odd write loads the mask, and an odd read returns it. Mask bit n set keeps IRQ n from raising int_o or being polled.
- R4: In edge mode a request latches on a rising input and clears whenever the input is low. An input that is already high at initialization must fall and rise again before it counts. In level mode the request follows the input.
- R5: An even write with bits 7..5 = 110 makes bits 2..0 the lowest level. Ranks then run from that level plus one, upward modulo 8.
- R6: int_o is high exactly when the best unmasked request ranks strictly above every blocking in-service level. Without special mask mode, every in-service level blocks.
- R7: An even write with bit 4 = 0 and bit 3 = 1 is a read-select command. If bit 1 = 1, bit 0 chooses what even reads return: 1 selects the in-service register, 0 selects the request register.
- R8: A read-select command with bit 2 set arms a poll, and only the next even read uses it. With a request winning, that read returns 0x80 | id, sets the in-service bit and clears that request latch. With none winning, it returns 0x07 and changes no state.
- R9: An even write with bits 7..5 = 011 clears the in-service bit named by bits 2..0. A blocked lower request then raises int_o again.
- R10: A read-select command with bit 6 = 1 loads special mask mode from bit 5 (0x68 turns it on). In this mode, in-service bits of masked levels block nothing.
- R11: If an edge request vanishes before the poll, the poll returns 0x07 and the in-service register stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Interrupt request inputs, synchronous to clk_i |
| wr_i | input | 1 | Byte write strobe |
| rd_i | input | 1 | Byte read strobe |
| addr_i | input | 1 | 0 = command/status, 1 = mask/init data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (mask, poll byte, request or in-service register) |
| int_o | output | 1 | Interrupt to the host |

## Verification
The assertions assume that a read and a write never fall in the same cycle. This keeps a poll acknowledge separate from an end-of-interrupt or an init write. They also assume the request inputs are already synchronous to the clock. The stimulus drives every strobe for one cycle and leaves an idle cycle between accesses. Request inputs change only at the falling clock edge.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NUM_IRQ = 8;
  localparam int ID_W    = $clog2(NUM_IRQ);
  localparam int RANK_W  = ID_W + 1;

  typedef logic [NUM_IRQ-1:0] irq_vec_t;
  typedef logic [ID_W-1:0]    irq_id_t;
  typedef logic [RANK_W-1:0]  rank_t;

  typedef enum logic [1:0] {ST_READY, ST_ICW2, ST_ICW3, ST_ICW4} init_st_e;

  localparam logic [2:0] OP_SET_PRIO = 3'b110;
  localparam logic [2:0] OP_SPEC_EOI = 3'b011;

  localparam int B_INIT   = 4;
  localparam int B_SEL3   = 3;
  localparam int B_POLL   = 2;
  localparam int B_RR     = 1;
  localparam int B_RIS    = 0;
  localparam int B_ESMM   = 6;
  localparam int B_SMM    = 5;
  localparam int B_LTIM   = 3;
  localparam int B_SNGL   = 1;
  localparam int B_IC4    = 0;
endpackage

// File: rtl/pic_cmd_port.sv
module pic_cmd_port
  import pic_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  logic     rd_i,
  input  logic     addr_i,
  input  logic [NUM_IRQ-1:0] wdata_i,
  output irq_vec_t mask_o,
  output irq_id_t  low_o,
  output logic     smm_o,
  output logic     isr_sel_o,
  output logic     poll_arm_o,
  output logic     lvl_mode_o,
  output logic     init_o,
  output logic     eoi_o,
  output irq_id_t  eoi_lvl_o,
  output logic     poll_rd_o
);
  init_st_e st_q;
  logic     need3_q, need4_q;
  irq_vec_t mask_q;
  irq_id_t  low_q;
  logic     smm_q, isr_sel_q, poll_q, lvl_q;

  logic cmd_wr, icw1, ocw2, ocw3, dat_wr;
  assign cmd_wr = wr_i & ~addr_i;
  assign icw1   = cmd_wr & wdata_i[B_INIT];
  assign ocw2   = cmd_wr & ~wdata_i[B_INIT] & ~wdata_i[B_SEL3];
  assign ocw3   = cmd_wr & ~wdata_i[B_INIT] &  wdata_i[B_SEL3];
  assign dat_wr = wr_i & addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_READY;
      need3_q   <= 1'b0;
      need4_q   <= 1'b0;
      mask_q    <= '1;
      low_q     <= irq_id_t'(NUM_IRQ - 1);
      smm_q     <= 1'b0;
      isr_sel_q <= 1'b0;
      poll_q    <= 1'b0;
      lvl_q     <= 1'b0;
    end else begin
      if (rd_i && !addr_i) poll_q <= 1'b0;
      if (icw1) begin
        st_q      <= ST_ICW2;
        need3_q   <= ~wdata_i[B_SNGL];
        need4_q   <= wdata_i[B_IC4];
        lvl_q     <= wdata_i[B_LTIM];
        mask_q    <= '0;
        low_q     <= irq_id_t'(NUM_IRQ - 1);
        smm_q     <= 1'b0;
        isr_sel_q <= 1'b0;
        poll_q    <= 1'b0;
      end else if (ocw2) begin
        if (wdata_i[7:5] == OP_SET_PRIO) low_q <= wdata_i[ID_W-1:0];
      end else if (ocw3) begin
        if (wdata_i[B_ESMM]) smm_q <= wdata_i[B_SMM];
        if (wdata_i[B_RR])   isr_sel_q <= wdata_i[B_RIS];
        poll_q <= wdata_i[B_POLL];
      end else if (dat_wr) begin
        unique case (st_q)
          ST_READY: mask_q <= wdata_i;
          ST_ICW2:  st_q <= need3_q ? ST_ICW3 : (need4_q ? ST_ICW4 : ST_READY);
          ST_ICW3:  st_q <= need4_q ? ST_ICW4 : ST_READY;
          default:  st_q <= ST_READY;
        endcase
      end
    end
  end

  assign mask_o     = mask_q;
  assign low_o      = low_q;
  assign smm_o      = smm_q;
  assign isr_sel_o  = isr_sel_q;
  assign poll_arm_o = poll_q;
  assign lvl_mode_o = lvl_q;
  assign init_o     = icw1;
  assign eoi_o      = ocw2 && (wdata_i[7:5] == OP_SPEC_EOI);
  assign eoi_lvl_o  = wdata_i[ID_W-1:0];
  assign poll_rd_o  = rd_i & ~addr_i & poll_q;

  AST_INIT_KEEPS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_READY && dat_wr) |=> (mask_o == $past(mask_o)));  // R2
  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_READY && dat_wr) |=> (mask_o == $past(wdata_i)));  // R3
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch
  import pic_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  irq_vec_t irq_i,
  input  logic     lvl_mode_i,
  input  logic     init_i,
  input  irq_vec_t clr_i,
  output irq_vec_t irr_o
);
  irq_vec_t irr_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q  <= '0;
      prev_q <= '1;
    end else if (init_i) begin
      irr_q  <= '0;
      prev_q <= '1;  // input held high at init must re-rise
    end else begin
      prev_q <= irq_i;
      irr_q  <= (lvl_mode_i ? irq_i : ((irr_q | (irq_i & ~prev_q)) & irq_i)) & ~clr_i;
    end
  end

  assign irr_o = irr_q;

  AST_REQ_NEEDS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((irr_q & ~$past(irq_i)) == '0));  // R4
endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve
  import pic_pkg::*;
(
  input  irq_vec_t req_i,
  input  irq_vec_t blk_i,
  input  irq_id_t  low_i,
  output logic     hit_o,
  output irq_id_t  id_o,
  output irq_vec_t grant_o
);
  logic    req_hit, blk_hit;
  rank_t   req_rank, blk_rank;
  irq_id_t req_id, lvl;

  always_comb begin
    req_hit  = 1'b0;
    blk_hit  = 1'b0;
    req_rank = '0;
    blk_rank = '0;
    req_id   = '0;
    lvl      = '0;
    for (int k = 0; k < NUM_IRQ; k++) begin
      lvl = irq_id_t'((int'(low_i) + 1 + k) % NUM_IRQ);
      if (!req_hit && req_i[lvl]) begin
        req_hit  = 1'b1;
        req_rank = rank_t'(k);
        req_id   = lvl;
      end
      if (!blk_hit && blk_i[lvl]) begin
        blk_hit  = 1'b1;
        blk_rank = rank_t'(k);
      end
    end
  end

  assign hit_o   = req_hit && (!blk_hit || (req_rank < blk_rank));
  assign id_o    = req_id;
  assign grant_o = hit_o ? (irq_vec_t'(1) << req_id) : '0;
endmodule

// File: rtl/pic_poll_ctrl.sv
module pic_poll_ctrl
  import pic_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] irq_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       int_o
);
  irq_vec_t mask, irr, isr_q, req, blk, grant, ack_clr;
  irq_id_t  low, eoi_lvl, hit_id;
  logic     smm, isr_sel, poll_arm, lvl_mode, init, eoi, poll_rd, hit, poll_ack;

  pic_cmd_port i_cmd (
    .clk_i, .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i,
    .mask_o(mask), .low_o(low), .smm_o(smm), .isr_sel_o(isr_sel),
    .poll_arm_o(poll_arm), .lvl_mode_o(lvl_mode), .init_o(init),
    .eoi_o(eoi), .eoi_lvl_o(eoi_lvl), .poll_rd_o(poll_rd)
  );

  pic_req_latch i_req (
    .clk_i, .rst_ni, .irq_i, .lvl_mode_i(lvl_mode), .init_i(init),
    .clr_i(ack_clr), .irr_o(irr)
  );

  assign req = irr & ~mask;
  assign blk = smm ? (isr_q & ~mask) : isr_q;

  pic_prio_resolve i_res (
    .req_i(req), .blk_i(blk), .low_i(low),
    .hit_o(hit), .id_o(hit_id), .grant_o(grant)
  );

  assign poll_ack = poll_rd & hit;
  assign ack_clr  = poll_ack ? grant : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   isr_q <= '0;
    else if (init) isr_q <= '0;
    else           isr_q <= (isr_q | ack_clr) & ~(eoi ? (irq_vec_t'(1) << eoi_lvl) : '0);
  end

  logic [7:0] poll_byte;
  assign poll_byte = hit ? {1'b1, 4'b0000, hit_id} : 8'h07;
  assign rdata_o   = addr_i ? mask : (poll_arm ? poll_byte : (isr_sel ? isr_q : irr));
  assign int_o     = hit;

  AST_NO_RD_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && wr_i));  // input assumption
  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));  // R6
  AST_INT_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((irr & ~mask) != '0));  // R6
  AST_GRANT_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grant & mask) == '0));  // R3
  AST_POLL_SETS_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_ack |=> isr_q[$past(hit_id)]);  // R8
  AST_EOI_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi && !poll_ack) |=> !isr_q[$past(eoi_lvl)]);  // R9
  AST_INIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init |=> (isr_q == '0 && irr == '0 && mask == '0));  // R2
endmodule

// File: tb/test_pic_poll_ctrl.sv
module test_pic_poll_ctrl;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       wr = 1'b0, rd = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       int_w;

  int n_chk = 0, n_fail = 0;

  pic_poll_ctrl i_pic_poll_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .int_o(int_w)
  );

  always #(CLK_P/2) clk = ~clk;

  // reference model
  logic [7:0] m_mask, m_irr, m_isr, m_prev;
  int m_low, m_step;
  bit m_smm, m_rsel, m_poll, m_lvl, m_need3, m_need4;

  function automatic int rank_of(int lvl);
    return (lvl - m_low - 1 + 16) % 8;
  endfunction

  function automatic int m_best();
    int rb = 99, bid = -1, kb = 99;
    logic [7:0] r = m_irr & ~m_mask;
    logic [7:0] b = m_smm ? (m_isr & ~m_mask) : m_isr;
    for (int l = 0; l < 8; l++) begin
      if (r[l] && rank_of(l) < rb) begin rb = rank_of(l); bid = l; end
      if (b[l] && rank_of(l) < kb) kb = rank_of(l);
    end
    return (bid >= 0 && rb < kb) ? bid : -1;
  endfunction

  function automatic logic [7:0] m_read(bit a);
    int b = m_best();
    if (a) return m_mask;
    if (m_poll) return (b >= 0) ? (8'h80 | 8'(b)) : 8'h07;
    return m_rsel ? m_isr : m_irr;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 8'hFF; m_irr = 0; m_isr = 0; m_prev = 8'hFF; m_low = 7; m_step = 0;
      m_smm = 0; m_rsel = 0; m_poll = 0; m_lvl = 0; m_need3 = 0; m_need4 = 0;
    end else begin
      int b;
      logic [7:0] nirr, nprev;
      b = m_best();
      nirr = m_lvl ? irq : ((m_irr | (irq & ~m_prev)) & irq);
      nprev = irq;
      if (rd && !addr && m_poll && b >= 0) begin nirr[b] = 1'b0; m_isr[b] = 1'b1; end
      if (rd && !addr) m_poll = 0;
      if (wr && !addr && wdata[4]) begin
        m_step = 1; m_need3 = !wdata[1]; m_need4 = wdata[0]; m_lvl = wdata[3];
        m_mask = 0; m_low = 7; m_smm = 0; m_rsel = 0; m_poll = 0; m_isr = 0;
        nirr = 0; nprev = 8'hFF;
      end else if (wr && !addr && !wdata[3]) begin
        if (wdata[7:5] == 3'd6) m_low = int'(wdata[2:0]);
        if (wdata[7:5] == 3'd3) m_isr[wdata[2:0]] = 1'b0;
      end else if (wr && !addr) begin
        if (wdata[6]) m_smm = wdata[5];
        if (wdata[1]) m_rsel = wdata[0];
        m_poll = wdata[2];
      end else if (wr && addr) begin
        case (m_step)
          0: m_mask = wdata;
          1: m_step = m_need3 ? 2 : (m_need4 ? 3 : 0);
          2: m_step = m_need4 ? 3 : 0;
          default: m_step = 0;
        endcase
      end
      m_irr = nirr; m_prev = nprev;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // every-clock comparison of the interrupt line
  always @(negedge clk) if (rst_n) begin
    logic e;
    e = (m_best() >= 0);
    check(int_w == e, "R6", int'(int_w), int'(e));
  end

  task automatic wr_b(bit a, logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0; addr = 0;
  endtask

  task automatic rd_b(bit a, int exp, string req);
    logic [7:0] m;
    @(negedge clk); rd = 1; addr = a;
    #1;
    m = m_read(a);
    check(rdata == m, req, int'(rdata), int'(m));
    if (exp >= 0) check(rdata == 8'(exp), req, int'(rdata), exp);
    @(negedge clk); rd = 0; addr = 0;
  endtask

  task automatic set_irq(logic [7:0] v);
    @(negedge clk); irq = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic int_is(bit e, string req);
    #1 check(int_w == e, req, int'(int_w), int'(e));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    // R1 reset state
    int_is(0, "R1");
    rd_b(0, 8'h00, "R1");
    rd_b(1, 8'hFF, "R1");
    // R2 init sequence, edge mode, cascade, fourth word
    wr_b(0, 8'h11); wr_b(1, 8'h00); wr_b(1, 8'h04); wr_b(1, 8'h01);
    rd_b(1, 8'h00, "R2");
    // R3 mask load and readback
    wr_b(1, 8'hFF); rd_b(1, 8'hFF, "R3");
    wr_b(0, 8'hC2);
    wr_b(1, 8'h00); rd_b(1, 8'h00, "R3");
    // R8 poll, R7 read select, R9 specific EOI
    set_irq(8'h28); idle(2);
    int_is(1, "R6");
    wr_b(0, 8'h0C); rd_b(0, 8'h83, "R8");
    int_is(0, "R6");
    wr_b(0, 8'h0B); rd_b(0, 8'h08, "R7");
    wr_b(0, 8'h0A); rd_b(0, 8'h20, "R7");
    wr_b(0, 8'h63); idle(1);
    int_is(1, "R9");
    wr_b(0, 8'h0C); rd_b(0, 8'h85, "R8");
    wr_b(0, 8'h65); set_irq(8'h00); idle(2);
    // R5 rotated priority: 7 beats 0 with lowest=2, then lowest=7
    set_irq(8'h81); idle(2);
    wr_b(0, 8'h0C); rd_b(0, 8'h87, "R5");
    wr_b(0, 8'h0B); rd_b(0, 8'h80, "R5");
    wr_b(0, 8'hC7); idle(1);
    int_is(1, "R5");
    wr_b(0, 8'h0C); rd_b(0, 8'h80, "R5");
    wr_b(0, 8'h0B); rd_b(0, 8'h81, "R7");
    wr_b(0, 8'h60); wr_b(0, 8'h67); set_irq(8'h00); idle(2);
    // R11 vanished request
    set_irq(8'h40); idle(2);
    int_is(1, "R4");
    set_irq(8'h00); idle(2);
    int_is(0, "R11");
    wr_b(0, 8'h0C); rd_b(0, 8'h07, "R11");
    wr_b(0, 8'h0B); rd_b(0, 8'h00, "R11");
    // R8 poll with nothing pending changes nothing
    wr_b(0, 8'h0C); rd_b(0, 8'h07, "R8");
    rd_b(0, 8'h00, "R8");
    // R3 masked request
    wr_b(1, 8'h10); set_irq(8'h10); idle(2);
    int_is(0, "R3");
    wr_b(0, 8'h0A); rd_b(0, 8'h10, "R7");
    wr_b(1, 8'h00); idle(1);
    int_is(1, "R3");
    wr_b(0, 8'h0C); rd_b(0, 8'h84, "R8");
    wr_b(0, 8'h64); set_irq(8'h00); idle(2);
    // R10 special mask mode
    wr_b(0, 8'hC2);
    set_irq(8'h08); idle(2);
    wr_b(0, 8'h0C); rd_b(0, 8'h83, "R8");
    set_irq(8'h20); wr_b(1, 8'h08); idle(1);
    int_is(0, "R6");
    wr_b(0, 8'h68); idle(1);
    int_is(1, "R10");
    wr_b(0, 8'h48); idle(1);
    int_is(0, "R10");
    wr_b(0, 8'h68);
    wr_b(0, 8'h0C); rd_b(0, 8'h85, "R10");
    wr_b(0, 8'h48); wr_b(0, 8'h63); wr_b(0, 8'h65); wr_b(1, 8'h00);
    set_irq(8'h00); idle(2);
    // R2 single-mode init with level trigger, R4 level mode
    wr_b(0, 8'h1B); wr_b(1, 8'h00); wr_b(1, 8'h01);
    wr_b(1, 8'h5A); rd_b(1, 8'h5A, "R2");
    set_irq(8'h04); wr_b(1, 8'h00); idle(1);
    int_is(1, "R4");
    wr_b(0, 8'h0C); rd_b(0, 8'h82, "R8");
    wr_b(0, 8'h62); idle(1);
    int_is(1, "R4");
    set_irq(8'h00); idle(2);
    int_is(0, "R4");
    // R4 edge mode ignores input already high at init
    set_irq(8'h02);
    wr_b(0, 8'h11); wr_b(1, 8'h00); wr_b(1, 8'h04); wr_b(1, 8'h01);
    wr_b(1, 8'h00); idle(3);
    int_is(0, "R4");
    set_irq(8'h00); idle(1); set_irq(8'h02); idle(2);
    int_is(1, "R4");
    wr_b(0, 8'h0C); rd_b(0, 8'h81, "R8");
    idle(3);
    finish_run();
  end
endmodule